// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Tracker

This block watches the command pins and the clock-enable pin of a synchronous DRAM bus, cycle by cycle. It works out which clock-enable state the memory device is in: normal operation, power-down, self refresh, recovery after self refresh, or clock suspend. Every decision combines three things: the clock-enable level stored from the previous cycle, the level in the current cycle, and the command decoded in the current cycle. A separate input tells the tracker that both banks are idle.

The outputs are the current state, a one-cycle illegal-command flag and a one-cycle pulse for each accepted auto refresh. A controller model or a bus monitor can place the tracker beside the bus to shadow the device, or to catch a sequence the device would reject. Two parameters set the recovery timing in clock cycles. `TRC_CYC` is the time the device spends in recovery. `TSREX_CYC` is the guard window, counted from the self-refresh exit edge, during which real commands are not allowed. The block has no data stream, so every pin is a plain level and there is no handshake.

Top module: `sdram_cke_tracker`

## Requirements
- R1: A synchronous active-high reset puts the block in normal state, with `illegal_o`=0, `aref_o`=0 and the stored previous clock-enable level set high. As a result, a low `cke` on the first cycle after reset, with banks idle and a no-op, counts as a falling edge. State codes on `state_o`: 0 normal, 1 power-down, 2 self refresh, 3 self-refresh recovery, 4 clock suspend. Command codes on {cs_n,ras_n,cas_n,we_n}: any pattern with cs_n=1 is deselect, 0111 is no-op and 0001 is auto refresh.
- R2: In normal state, with previous and current `cke` both high, banks idle and no guard window open, an auto-refresh command drives `aref_o` high for exactly one cycle, in the cycle after its clock edge. No other command produces the pulse, and neither does an auto refresh while the banks are busy.
- R3: In normal state, with banks idle, `cke` falling from high to low together with auto refresh enters self refresh. The same fall together with deselect or no-op enters power-down. When the banks are not idle, the block never enters either of these states.
- R4: In normal state, any other fall of `cke` to low, including a fall while the banks are busy, enters clock suspend on the next cycle. Clock suspend holds while `cke` stays low, and the block returns to normal on the cycle after `cke` goes high.
- R5: Power-down holds while `cke` stays low, and the block returns to normal on the cycle after `cke` goes high.
- R6: Self refresh holds while `cke` stays low. A cycle with `cke` high and deselect or no-op moves the block to recovery. A cycle with `cke` high and any other command raises `illegal_o` and leaves the block in self refresh.
- R7: Recovery lasts exactly `TRC_CYC` cycles and then the block returns to normal. During recovery, a command other than deselect or no-op, or a low `cke`, raises `illegal_o`. When such a cycle falls on the last recovery cycle, the return to normal is delayed by one cycle.
- R8: Once normal state is reached again, a command other than deselect or no-op that is sampled within the first `TSREX_CYC` clock edges after the self-refresh exit edge raises `illegal_o`. During that window, an auto refresh gives no `aref_o` pulse.
- R9: `illegal_o` and `aref_o` are registered. Each is high only in the cycle after the clock edge that sampled the cause, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock-enable level seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| banks_idle | input | 1 | High when both banks are idle |
| state_o | output | 3 | Tracked state code (see R1) |
| illegal_o | output | 1 | One-cycle flag for a command the device would reject |
| aref_o | output | 1 | One-cycle pulse for an accepted auto refresh |

## Verification
A wrong state shows on `state_o` in the cycle after the edge that caused it. A wrong stored clock-enable level shows later, because the state moves to power-down or clock suspend on an edge where it should have stayed put. A recovery counter that is off by one shifts the return to normal, or the last illegal flag of the guard window, by exactly one cycle. For that reason the bench compares every output on every cycle against its own model, so each error is caught in the first cycle it appears. Directed sequences hit each counter boundary exactly, and random traffic mixes the clock-enable level, the banks-idle flag and the commands.

// File: rtl/cke_trk_pkg.sv
package cke_trk_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL = 3'd0,
    ST_PDOWN  = 3'd1,
    ST_SREF   = 3'd2,
    ST_SREC   = 3'd3,
    ST_SUSP   = 3'd4
  } trk_state_t;

  typedef struct packed {
    logic quiet;   // deselect or no-op
    logic aref;    // auto refresh
  } cmd_kind_t;

endpackage

// File: rtl/cke_cmd_decode.sv
module cke_cmd_decode
  import cke_trk_pkg::*;
(
  input  logic      cs_n,
  input  logic      ras_n,
  input  logic      cas_n,
  input  logic      we_n,
  output cmd_kind_t kind
);

  always_comb begin
    kind.quiet = cs_n | (ras_n & cas_n & we_n);
    kind.aref  = ~cs_n & ~ras_n & ~cas_n & we_n;
  end

endmodule

// File: rtl/cke_rec_timer.sv
module cke_rec_timer #(
  parameter int TRC_CYC   = 4,
  parameter int TSREX_CYC = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic rc_done,
  output logic guard_busy
);

  localparam int RW = (TRC_CYC   > 1) ? $clog2(TRC_CYC + 1)   : 1;
  localparam int SW = (TSREX_CYC > 1) ? $clog2(TSREX_CYC + 1) : 1;
  localparam logic [RW-1:0] RC_LOAD = RW'(TRC_CYC - 1);
  localparam logic [SW-1:0] SX_LOAD = SW'(TSREX_CYC);

  logic [RW-1:0] rc_left;
  logic [SW-1:0] sx_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      rc_left <= '0;
      sx_left <= '0;
    end else if (load) begin
      rc_left <= RC_LOAD;
      sx_left <= SX_LOAD;
    end else begin
      if (rc_left != '0) rc_left <= rc_left - 1'b1;
      if (sx_left != '0) sx_left <= sx_left - 1'b1;
    end
  end

  assign rc_done    = (rc_left == '0);
  assign guard_busy = (sx_left != '0);

  a_r7_rc_range: assert property (@(posedge clk) disable iff (rst)
    rc_left <= RC_LOAD);

  a_r8_guard_after_load: assert property (@(posedge clk) disable iff (rst)
    load |=> guard_busy);

endmodule

// File: rtl/cke_state_fsm.sv
module cke_state_fsm
  import cke_trk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cke,
  input  logic       banks_idle,
  input  cmd_kind_t  kind,
  input  logic       rc_done,
  input  logic       guard_busy,
  output logic       load,
  output trk_state_t state_q,
  output logic       illegal_q,
  output logic       aref_q
);

  trk_state_t nxt;
  logic       cke_q;
  logic       ill_d;
  logic       ar_d;

  always_comb begin
    nxt   = state_q;
    ill_d = 1'b0;
    ar_d  = 1'b0;
    load  = 1'b0;
    unique case (state_q)
      ST_NORMAL: begin
        if (guard_busy && !kind.quiet) ill_d = 1'b1;
        if (!cke) begin
          if (banks_idle && cke_q && kind.aref)       nxt = ST_SREF;
          else if (banks_idle && cke_q && kind.quiet) nxt = ST_PDOWN;
          else                                        nxt = ST_SUSP;
        end else if (cke_q && banks_idle && kind.aref && !guard_busy) begin
          ar_d = 1'b1;
        end
      end
      ST_SUSP:  if (cke) nxt = ST_NORMAL;
      ST_PDOWN: if (cke) nxt = ST_NORMAL;
      ST_SREF: begin
        if (cke) begin
          if (kind.quiet) begin
            nxt  = ST_SREC;
            load = 1'b1;
          end else begin
            ill_d = 1'b1;
          end
        end
      end
      ST_SREC: begin
        if (!cke || !kind.quiet) ill_d = 1'b1;
        else if (rc_done)        nxt   = ST_NORMAL;
      end
      default: nxt = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_NORMAL;
      cke_q     <= 1'b1;
      illegal_q <= 1'b0;
      aref_q    <= 1'b0;
    end else begin
      state_q   <= nxt;
      cke_q     <= cke;
      illegal_q <= ill_d;
      aref_q    <= ar_d;
    end
  end

  a_r3_busy_no_lowpower: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_NORMAL && !banks_idle) |=> (state_q != ST_PDOWN && state_q != ST_SREF));

  a_r4_susp_exit: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SUSP && cke) |=> state_q == ST_NORMAL);

  a_r5_pd_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PDOWN && !cke) |=> state_q == ST_PDOWN);

  a_r6_sref_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SREF && !cke) |=> state_q == ST_SREF);

  a_r7_srec_bad_flag: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SREC && (!cke || !kind.quiet)) |=> (illegal_q && state_q == ST_SREC));

  a_r2_aref_idle: assert property (@(posedge clk) disable iff (rst)
    aref_q |-> ($past(banks_idle) && $past(kind.aref)));

  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(aref_q && illegal_q));

endmodule

// File: rtl/sdram_cke_tracker.sv
module sdram_cke_tracker
  import cke_trk_pkg::*;
#(
  parameter int TRC_CYC   = 4,
  parameter int TSREX_CYC = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       banks_idle,
  output logic [2:0] state_o,
  output logic       illegal_o,
  output logic       aref_o
);

  cmd_kind_t  kind;
  logic       rc_done;
  logic       guard_busy;
  logic       load;
  trk_state_t state_q;

  cke_cmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .kind  (kind)
  );

  cke_rec_timer #(
    .TRC_CYC   (TRC_CYC),
    .TSREX_CYC (TSREX_CYC)
  ) u_tmr (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .rc_done    (rc_done),
    .guard_busy (guard_busy)
  );

  cke_state_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .cke        (cke),
    .banks_idle (banks_idle),
    .kind       (kind),
    .rc_done    (rc_done),
    .guard_busy (guard_busy),
    .load       (load),
    .state_q    (state_q),
    .illegal_q  (illegal_o),
    .aref_q     (aref_o)
  );

  assign state_o = state_q;

endmodule

// File: tb/test_sdram_cke_tracker.sv
module test_sdram_cke_tracker;

  localparam int TRC   = 4;
  localparam int TSREX = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic banks_idle = 1'b1;
  logic [2:0] state_o;
  logic illegal_o, aref_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int m_state, m_rc, m_sx;
  bit m_ckeq, m_ill, m_ar;

  always #5 clk = ~clk;

  sdram_cke_tracker #(.TRC_CYC(TRC), .TSREX_CYC(TSREX)) i_sdram_cke_tracker (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .banks_idle(banks_idle), .state_o(state_o),
    .illegal_o(illegal_o), .aref_o(aref_o)
  );

  // command codes: 0 deselect,1 nop,2 auto refresh,3 activate,4 read,5 write,6 precharge,7 mode
  function automatic logic [3:0] pins(input int c);
    case (c)
      0: pins = 4'b1111;
      1: pins = 4'b0111;
      2: pins = 4'b0001;
      3: pins = 4'b0011;
      4: pins = 4'b0101;
      5: pins = 4'b0100;
      6: pins = 4'b0010;
      default: pins = 4'b0000;
    endcase
  endfunction

  function automatic bit is_quiet(input int c);
    return (c == 0) || (c == 1);
  endfunction

  task automatic model_reset();
    m_state = 0; m_ckeq = 1; m_rc = 0; m_sx = 0; m_ill = 0; m_ar = 0;
  endtask

  task automatic model_step(input bit k, input int c, input bit idle);
    int ns, nrc, nsx;
    bit ill, ar, ld;
    ns = m_state; ill = 0; ar = 0; ld = 0;
    case (m_state)
      0: begin
        if (m_sx != 0 && !is_quiet(c)) ill = 1;
        if (!k) begin
          if (idle && m_ckeq && c == 2)            ns = 2;
          else if (idle && m_ckeq && is_quiet(c))  ns = 1;
          else                                     ns = 4;
        end else if (m_ckeq && idle && c == 2 && m_sx == 0) ar = 1;
      end
      1, 4: if (k) ns = 0;
      2: if (k) begin
        if (is_quiet(c)) begin ns = 3; ld = 1; end else ill = 1;
      end
      default: begin
        if (!k || !is_quiet(c)) ill = 1;
        else if (m_rc == 0)     ns = 0;
      end
    endcase
    nrc = (m_rc > 0) ? m_rc - 1 : 0;
    nsx = (m_sx > 0) ? m_sx - 1 : 0;
    if (ld) begin nrc = TRC - 1; nsx = TSREX; end
    m_state = ns; m_rc = nrc; m_sx = nsx; m_ill = ill; m_ar = ar; m_ckeq = k;
  endtask

  task automatic check(input string tag);
    total++;
    if (state_o != 3'(m_state) || illegal_o != m_ill || aref_o != m_ar) begin
      bad++;
      $display("FAIL %s: state=%0d ill=%0b aref=%0b expected state=%0d ill=%0b aref=%0b",
               tag, state_o, illegal_o, aref_o, m_state, m_ill, m_ar);
    end
  endtask

  task automatic cyc(input bit k, input int c, input bit idle, input string tag);
    @(negedge clk);
    cke = k; banks_idle = idle;
    {cs_n, ras_n, cas_n, we_n} = pins(c);
    @(posedge clk);
    #1;
    model_step(k, c, idle);
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1; check("R1 reset state");
    // R1: prev cke reset high -> immediate fall enters power-down
    cyc(0, 1, 1, "R1 prev cke high after reset");
    cyc(0, 1, 1, "R5 pd hold");
    cyc(0, 4, 1, "R5 pd hold any cmd");
    cyc(1, 1, 1, "R5 pd exit");
    cyc(1, 1, 1, "R5 normal");
    // R2
    cyc(1, 2, 1, "R2 aref accepted");
    cyc(1, 1, 1, "R2 pulse one cycle");
    cyc(1, 2, 0, "R2 aref busy banks ignored");
    cyc(1, 4, 1, "R2 read no pulse");
    // R4 suspend with busy banks
    cyc(0, 1, 0, "R4 busy fall suspend");
    cyc(0, 4, 0, "R4 suspend hold");
    cyc(1, 4, 0, "R4 suspend exit");
    cyc(1, 1, 1, "R4 normal");
    cyc(0, 4, 1, "R4 idle fall with read suspends");
    cyc(1, 1, 1, "R4 exit");
    // R3 self refresh entry
    cyc(1, 1, 1, "R3 prep");
    cyc(0, 2, 1, "R3 enter self refresh");
    cyc(0, 1, 1, "R6 sref hold");
    cyc(0, 4, 1, "R6 sref hold any cmd");
    cyc(1, 4, 1, "R6 illegal exit cmd");
    cyc(1, 1, 1, "R6 exit to recovery");
    cyc(1, 0, 1, "R7 recovery");
    cyc(1, 5, 1, "R7 illegal in recovery");
    cyc(1, 1, 1, "R7 recovery");
    cyc(1, 1, 1, "R7 recovery end");
    cyc(1, 2, 1, "R8 aref in guard illegal");
    cyc(1, 4, 1, "R8 read in guard illegal");
    cyc(1, 1, 1, "R8 guard quiet");
    cyc(1, 1, 1, "R8 guard quiet");
    cyc(1, 2, 1, "R8 aref after guard accepted");
    // R7 last-cycle violation delays exit
    cyc(0, 2, 1, "R3 enter self refresh again");
    cyc(1, 0, 1, "R6 exit to recovery");
    cyc(1, 1, 1, "R7 rec");
    cyc(1, 1, 1, "R7 rec");
    cyc(1, 1, 1, "R7 rec");
    cyc(0, 1, 1, "R7 cke low on last cycle illegal");
    cyc(1, 1, 1, "R7 delayed exit");
    repeat (8) cyc(1, 1, 1, "R8 drain");
    // R9 random traffic
    for (int i = 0; i < 4000; i++) begin
      bit k, idle;
      int c, r;
      r = $urandom_range(0, 99);
      k = (r < 75);
      idle = ($urandom_range(0, 3) != 0);
      r = $urandom_range(0, 9);
      c = (r < 4) ? (r & 1) : (r < 7) ? 2 : $urandom_range(3, 7);
      cyc(k, c, idle, "R9 random");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule